// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a bus target for a two-wire serial bus that sits in front of a byte-wide memory array. It watches the clock and data lines, which arrive already synchronized and deglitched, and it answers only when a control byte carries its device type code and the chip-select bits match three strap inputs. A write sequence loads a word pointer from two address bytes. Any data bytes that follow are gathered in a page buffer, and the buffer is committed to the array by a timed internal write cycle once the host ends the transfer. A read sequence streams bytes out from the pointer for as long as the host keeps acknowledging.

The data line is open drain. `sda_oe` high pulls the line low, and `sda_i` is the resolved line level. The array holds `2**ADDR_W` bytes in pages of `2**PAGE_W` bytes. The default width is kept small for elaboration, and an 8K array uses `ADDR_W = 13`. The length of the write cycle is set in clock cycles by `WCYC`, and `busy_o` is high for the whole of that cycle.

Top module: `i2c_eeprom_target`

## Requirements
- R1: While SCL is high, a falling SDA is a Start and a rising SDA is a Stop. Neither is taken as a data bit, and a Start in the middle of a byte abandons that byte.
- R2: The control byte arrives MSB first as type code 4'b1010, then chip selects A2,A1,A0, then R/W in bit 0 (1 = read). The target pulls SDA low on the ninth clock only when the code matches and A2..A0 equal `strap_i[2:0]`. In any other case it leaves SDA released until the next Start.
- R3: After a write control byte, a high address byte and then a low address byte follow, and both are acknowledged. The pointer takes the low ADDR_W bits of {high,low}, and the remaining high-byte bits are ignored.
- R4: Every data byte in a write is acknowledged and held in the page buffer. The array does not change unless the transfer ends with a Stop.
- R5: After each data byte only the low PAGE_W pointer bits advance, modulo the page size, and the page bits stay fixed. More bytes than a page holds therefore wrap, and later bytes replace earlier ones at the same offset.
- R6: A Stop that ends a write holding at least one data byte, with `wp_i` low, starts a write cycle. `busy_o` rises on the clock that sees the Stop and stays high for WCYC cycles. While `busy_o` is high, no control byte is acknowledged.
- R7: With `wp_i` high at the Stop, the whole write sequence is still acknowledged, but `busy_o` stays low and the array keeps its old contents.
- R8: After a write, the pointer holds the address that follows the last byte written, counted within the page. A read that starts without an address phase returns the byte at that location.
- R9: In a read, bytes are driven MSB first from the pointer and change only while SCL is low. The pointer advances over the whole ADDR_W space and wraps from the top address to 0. The target continues after a host ACK and releases SDA after a host NACK.
- R10: A repeated Start returns the target to control-byte reception. A Stop that follows the address bytes with no data bytes sets the pointer and does not start a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level, already synchronized |
| sda_i | input | 1 | Resolved serial data level, already synchronized |
| strap_i | input | 3 | Chip-select strap levels A2..A0 |
| wp_i | input | 1 | Write protect; high blocks array writes |
| sda_oe | output | 1 | High pulls SDA low (ACK or a 0 data bit) |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The target registers the line levels, so a Start or Stop takes effect on the first clock edge that sees the new SDA level, and `busy_o` is high one edge after the Stop. An ACK or read bit appears on `sda_oe` one clock after the SCL fall that precedes it. The host model changes lines only on falling clock edges and samples SDA in the middle of each SCL-high phase, several cycles after every such update. The busy flag is read one cycle after the Stop, and the next transfer waits WCYC plus a margin of cycles, so each check reads a settled value.

// File: rtl/i2c_eeprom_target.sv
`timescale 1ns/1ps
module i2c_eeprom_target #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5,
  parameter int WCYC = 1000000,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe,
  output logic       busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int CW    = $clog2(WCYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_AHI, S_ALO, S_WR, S_RD, S_SKIP} st_t;

  st_t               st;
  logic              scl_q, sda_q, ackph, drv, mack, have, busy;
  logic [3:0]        cnt;
  logic [7:0]        sr, tx;
  logic [HI_W-1:0]   hi;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE-1:0]   pval;
  logic [CW-1:0]     cyc;
  logic [7:0]        pbuf [PAGE];
  logic [7:0]        mem  [DEPTH];

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire active   = (st != S_IDLE) && (st != S_SKIP);
  wire byte_end = active && scl_fall && !ackph && (cnt == 4'd8);
  wire ack_end  = active && scl_fall && ackph;
  wire wr_byte  = byte_end && (st == S_WR);
  wire ctrl_ok  = (sr[7:4] == DEV_CODE) && (sr[3:1] == strap_i) && !busy;
  wire [PAGE_W-1:0] off = ptr[PAGE_W-1:0];
  wire [PAGE_W-1:0] cidx = cyc[PAGE_W-1:0];

  assign sda_oe = drv;
  assign busy_o = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      ackph <= 1'b0; drv <= 1'b0; mack <= 1'b0; have <= 1'b0;
      busy <= 1'b0; cnt <= '0; sr <= '0; tx <= '0; hi <= '0;
      ptr <= '0; pval <= '0; cyc <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (busy) begin
        cyc <= cyc + CW'(1);
        if (cyc == CW'(WCYC - 1)) busy <= 1'b0;
      end
      if (start_c) begin
        st <= S_CTRL; cnt <= '0; ackph <= 1'b0; drv <= 1'b0; have <= 1'b0;
      end else if (stop_c) begin
        if (st == S_WR && have && !wp_i) begin
          busy <= 1'b1;
          cyc  <= '0;
        end
        st <= S_IDLE; cnt <= '0; ackph <= 1'b0; drv <= 1'b0; have <= 1'b0;
      end else if (active) begin
        if (scl_rise && !ackph) begin
          sr  <= {sr[6:0], sda_i};
          cnt <= cnt + 4'd1;
        end else if (scl_rise && ackph && st == S_RD) begin
          mack <= ~sda_i;
        end
        if (byte_end) begin
          ackph <= 1'b1;
          case (st)
            S_CTRL: begin
              if (ctrl_ok) begin
                drv  <= 1'b1;
                mack <= 1'b1;
                st   <= sr[0] ? S_RD : S_AHI;
              end else begin
                st <= S_SKIP;
              end
            end
            S_AHI: begin
              drv <= 1'b1;
              hi  <= sr[HI_W-1:0];
              st  <= S_ALO;
            end
            S_ALO: begin
              drv  <= 1'b1;
              ptr  <= {hi, sr};
              pval <= '0;
              st   <= S_WR;
            end
            S_WR: begin
              drv <= 1'b1;
              ptr[PAGE_W-1:0] <= off + PAGE_W'(1);
              pval[off] <= 1'b1;
              have <= 1'b1;
            end
            S_RD: begin
              drv <= 1'b0;
              ptr <= ptr + ADDR_W'(1);
            end
            default: st <= S_SKIP;
          endcase
        end else if (ack_end) begin
          ackph <= 1'b0;
          cnt   <= '0;
          if (st == S_RD && mack) begin
            tx  <= mem[ptr];
            drv <= ~mem[ptr][7];
          end else begin
            drv <= 1'b0;
            if (st == S_RD) st <= S_SKIP;
          end
        end else if (scl_fall && st == S_RD && cnt != 4'd0) begin
          drv <= ~tx[3'd7 - cnt[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_byte) pbuf[off] <= sr;
  end

  always_ff @(posedge clk) begin
    if (busy && cyc < CW'(PAGE) && pval[cidx])
      mem[{ptr[ADDR_W-1:PAGE_W], cidx}] <= pbuf[cidx];
  end

  // R1
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == S_CTRL && cnt == 4'd0 && !drv));

  // R5
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == S_CTRL && byte_end) |=> !drv);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc < CW'(WCYC - 1)) |=> busy);

  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !drv);
endmodule

// File: tb/i2c_eeprom_target_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_target_bench;
  localparam int AW = 11;
  localparam int WC = 64;
  localparam int HP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic h_scl = 1'b1, h_sda = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, busy_o;
  wire sda_bus = h_sda & ~sda_oe;

  i2c_eeprom_target #(.ADDR_W(AW), .PAGE_W(5), .WCYC(WC)) u_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(h_scl), .sda_i(sda_bus),
    .strap_i(strap), .wp_i(wp), .sda_oe(sda_oe), .busy_o(busy_o));

  int total = 0, bad = 0;
  logic [7:0] model [2**AW];
  bit known [2**AW];
  logic [AW-1:0] mptr = '0;
  logic [7:0] wbuf [64];

  function automatic logic [7:0] ctrl_byte(bit rd, logic [2:0] cs);
    return {4'b1010, cs, rd};
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic h_start;
    h_sda = 1'b1; tw(HP); h_scl = 1'b1; tw(HP);
    h_sda = 1'b0; tw(HP); h_scl = 1'b0; tw(HP);
  endtask

  task automatic h_stop;
    h_sda = 1'b0; tw(HP); h_scl = 1'b1; tw(HP); h_sda = 1'b1; tw(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      h_sda = b[i]; tw(HP); h_scl = 1'b1; tw(HP); h_scl = 1'b0; tw(1);
    end
    h_sda = 1'b1; tw(HP); h_scl = 1'b1; tw(HP);
    ack = ~sda_bus;
    h_scl = 1'b0; tw(1);
  endtask

  task automatic recv_byte(input bit hack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      tw(HP); h_scl = 1'b1; tw(HP); b = {b[6:0], sda_bus}; h_scl = 1'b0;
    end
    tw(HP); h_sda = hack ? 1'b0 : 1'b1; tw(HP);
    h_scl = 1'b1; tw(HP); h_scl = 1'b0; tw(HP); h_sda = 1'b1;
  endtask

  task automatic addr_phase(input logic [15:0] a, output int nak);
    bit ack;
    nak = 0;
    send_byte(ctrl_byte(1'b0, strap), ack); if (!ack) nak++;
    send_byte(a[15:8], ack); if (!ack) nak++;
    send_byte(a[7:0], ack); if (!ack) nak++;
  endtask

  task automatic page_write(input logic [15:0] a, input int n);
    bit ack; int nak;
    logic [7:0] pb [32];
    bit pv [32];
    logic [4:0] o;
    for (int i = 0; i < 32; i++) pv[i] = 1'b0;
    h_start;
    addr_phase(a, nak);
    chk("R3 address acks", nak, 0);
    nak = 0;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); if (!ack) nak++;
      o = 5'(a[4:0] + i);
      pb[o] = wbuf[i]; pv[o] = 1'b1;
    end
    h_stop;
    chk(wp ? "R7 data acks" : "R4 data acks", nak, 0);
    tw(1);
    if (wp) chk("R7 busy stays low", busy_o, 0);
    else if (n == 0) chk("R10 no cycle", busy_o, 0);
    else chk("R6 busy after stop", busy_o, 1);
    if (n > 0 && !wp)
      for (int i = 0; i < 32; i++)
        if (pv[i]) begin
          model[{a[AW-1:5], 5'(i)}] = pb[i];
          known[{a[AW-1:5], 5'(i)}] = 1'b1;
        end
    mptr = (n > 0) ? {a[AW-1:5], 5'(a[4:0] + n)} : a[AW-1:0];
    tw(WC + 4);
  endtask

  task automatic read_body(input int n, input string tag);
    logic [7:0] b;
    logic [AW-1:0] ad;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      ad = AW'(mptr + i);
      if (known[ad]) chk(tag, b, model[ad]);
    end
    tw(1);
    chk("R9 released after NACK", sda_oe, 0);
    h_stop;
    mptr = AW'(mptr + n);
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string tag);
    bit ack; int nak;
    h_start;
    addr_phase(a, nak);
    h_start;
    send_byte(ctrl_byte(1'b1, strap), ack);
    chk("R10 repeated start read ack", int'(ack) + nak * 2, 1);
    mptr = a[AW-1:0];
    read_body(n, tag);
  endtask

  task automatic cur_read(input int n, input string tag);
    bit ack;
    h_start;
    send_byte(ctrl_byte(1'b1, strap), ack);
    chk("R2 read control ack", ack, 1);
    read_body(n, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack; int nak;
    logic [15:0] ra;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2**AW; i++) known[i] = 1'b0;
    tw(5); rst_n = 1'b1; tw(3);
    chk("R2 reset releases SDA", sda_oe, 0);
    chk("R6 reset not busy", busy_o, 0);

    h_start; send_byte(ctrl_byte(1'b0, strap ^ 3'b001), ack); h_stop;
    chk("R2 strap mismatch NACK", ack, 0);
    h_start; send_byte(8'hB0 | {4'h0, strap, 1'b0}, ack); h_stop;
    chk("R2 type code mismatch NACK", ack, 0);

    h_start;
    for (int i = 0; i < 3; i++) begin
      h_sda = 1'b0; tw(HP); h_scl = 1'b1; tw(HP); h_scl = 1'b0; tw(1);
    end
    h_start; send_byte(ctrl_byte(1'b0, strap), ack); h_stop;
    chk("R1 start abandons partial byte", ack, 1);
    tw(2);
    chk("R1 short transfer no cycle", busy_o, 0);

    for (int i = 0; i < 5; i++) wbuf[i] = 8'h30 + 8'(i);
    h_start; addr_phase(16'hE120, nak);
    for (int i = 0; i < 5; i++) send_byte(wbuf[i], ack);
    h_stop; tw(1);
    chk("R6 busy after page write", busy_o, 1);
    h_start; send_byte(ctrl_byte(1'b0, strap), ack); h_stop;
    chk("R6 control NACK while busy", ack, 0);
    tw(WC + 4);
    chk("R6 busy ends", busy_o, 0);
    for (int i = 0; i < 5; i++) begin
      model[11'h120 + i] = wbuf[i]; known[11'h120 + i] = 1'b1;
    end
    rand_read(16'h0120, 5, "R3 page readback");

    wbuf[0] = 8'h5A; page_write(16'h0122, 1);
    cur_read(1, "R8 pointer after byte write");

    wbuf[0] = 8'h11; page_write(16'h0300, 1);
    h_start; addr_phase(16'h0300, nak);
    send_byte(8'h77, ack);
    h_start; addr_phase(16'h0300, nak); h_stop; tw(1);
    chk("R10 address-only stop no cycle", busy_o, 0);
    mptr = 11'h300;
    cur_read(1, "R4 uncommitted data discarded");

    for (int i = 0; i < 35; i++) wbuf[i] = 8'hA0 + 8'(i);
    page_write(16'h041E, 35);
    rand_read(16'h0400, 32, "R5 page wrap overwrite");

    wp = 1'b1;
    for (int i = 0; i < 3; i++) wbuf[i] = 8'hEE;
    page_write(16'h0120, 3);
    wp = 1'b0;
    rand_read(16'h0120, 3, "R7 array unchanged");

    wbuf[0] = 8'hC3; page_write(16'h07FF, 1);
    wbuf[0] = 8'h3C; page_write(16'h0000, 1);
    rand_read(16'h07FF, 2, "R9 read wraps to 0");

    for (int t = 0; t < 16; t++) begin
      int n;
      ra = 16'($urandom);
      n = 1 + int'($urandom % 40);
      wp = ($urandom % 5) == 0;
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      page_write(ra, n);
      wp = 1'b0;
      if (t % 3 == 0) cur_read(3, "R8 random current read");
      else rand_read({5'($urandom), ra[AW-1:5], 5'd0}, 8, "R9 random sequential read");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule